// File: doc/BRIEF.md
# Burst-Locked Chroma Subcarrier Demodulator

This block recreates the colour subcarrier of a high-definition composite signal inside the receiver and uses it to split the chroma into its two colour-difference components. A 32-bit phase accumulator advances once per accepted composite sample. The top eleven bits of the accumulator select a sine and cosine value. Each value comes from a stored quarter wave and is folded out to a full period. The 10-bit sample is multiplied by both values to give raw U (sine product) and raw V (cosine product). The products still carry twice-subcarrier terms, which a downstream low-pass filter removes.

The filtered V from that downstream filter comes back to this block as feedback. While the burst gate is high, the block sums the first 32 feedback values. When the gate falls, the sum is arithmetically shifted right by a programmable amount and clamped to a programmable magnitude limit. The result is then added to the base step word, and the corrected step is held until the next burst closes. Because the correction is clamped, a missing or corrupt burst cannot drag the subcarrier far from its nominal frequency. A typical base step is 0x55417954, which puts the subcarrier at 549.5 times the line rate of a 1650-sample line at 74.25 MHz.

Samples enter on a valid/ready stream and results leave on another. A sample is taken on any clock where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied on that clock. While `out_valid` is high and `out_ready` is low, every output stays frozen and no new sample is taken. The phase advances only when a sample is accepted, so stalls never skip phase. The burst gate, feedback and configuration pins are plain level inputs that are sampled on every clock.

Top module: `sc_demod`

## Requirements
- R1: While reset is low, `out_valid` is 0. After reset, `in_ready` is 1, the phase accumulator is 0 (the first accepted sample uses phase word 0) and the loop correction is 0.
- R2: Each accepted sample uses the current accumulator value, and the accumulator then advances by the active step, which is `base_seed` plus the loop correction, modulo 2^32. The phase word is accumulator bits [31:21].
- R3: Phase word bits [10:9] select the quadrant and bits [8:0] give the angle inside it. At the quadrant starts (phase words 0, 512, 1024 and 1536), sine is exactly 0, 2047, 0, -2047 and cosine is exactly 2047, 0, -2047, 0.
- R4: `out_sin` and `out_cos` are signed 12-bit values that stay within ±2047. Each is within 6 of 2047·sin(2πp/2048) or 2047·cos(2πp/2048), where p is the phase word.
- R5: `out_u` equals the sample multiplied by `out_sin`, and `out_v` equals the sample multiplied by `out_cos`. The sample is treated as unsigned. Both products are signed 23 bits, one bit wider than the largest product needs, so a sample of 1023 never overflows.
- R6: A result appears on the clock after its sample is accepted. `in_ready` is low while a result is stalled (`out_valid` high and `out_ready` low), and all outputs hold stable until the result is taken.
- R7: Counting from the rising edge of the burst gate, only the first 32 clocks of `vfilt` are summed. Later feedback values within the same burst are ignored.
- R8: On the clock where the burst gate is first seen low, the correction becomes the sum arithmetically shifted right by `err_shift`. Samples accepted after that clock advance by `base_seed` plus the correction.
- R9: The correction is clamped to the range from -`corr_limit` to +`corr_limit`.
- R10: Between burst ends the correction does not change, and `vfilt` has no effect while the gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Composite sample present |
| in_ready | output | 1 | Block can take a sample this clock |
| in_sample | input | 10 | Composite sample, straight binary |
| burst_gate | input | 1 | High during the colour burst window |
| vfilt | input | 16 | Signed low-pass-filtered V feedback |
| base_seed | input | 32 | Nominal accumulator step |
| err_shift | input | 5 | Right shift applied to the burst error |
| corr_limit | input | 32 | Magnitude limit of the loop correction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this clock |
| out_u | output | 23 | Signed raw U (sample times sine) |
| out_v | output | 23 | Signed raw V (sample times cosine) |
| out_sin | output | 12 | Signed local sine |
| out_cos | output | 12 | Signed local cosine |

## Verification
A wrong accumulator or step value shows up in the sine and cosine of the next accepted sample. Because the error compounds, every later result is off as well. A bad quadrant fold shows up at the next quadrant boundary as a sign or swap error, within at most 2048/step samples. A miscounted burst sum, a wrong shift or a missed clamp stays hidden until the gate falls. After that it changes the phase steps of every sample that follows. The bench therefore streams several dozen samples after each burst and compares each phase against its own model of the step.

// File: rtl/sc_pkg.sv
package sc_pkg;

  // Bhaskara-style rational approximation of a sine, in integer form.
  // u spans 0..half, where half corresponds to 180 degrees.
  function automatic logic [11:0] qwave_val(input int unsigned u,
                                            input int unsigned half,
                                            input int unsigned amp);
    longint p;
    longint den;
    longint num;
    p   = longint'(u) * longint'(half - u);
    den = (longint'(5) * longint'(half) * longint'(half)) / 4 - p;
    num = longint'(amp) * 4 * p;
    return 12'(num / den);
  endfunction

endpackage

// File: rtl/sc_nco.sv
module sc_nco #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic [ACC_W-1:0]   step,
  output logic [PHASE_W-1:0] phase
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (advance) acc_q <= acc_q + step;
  end

  assign phase = acc_q[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/sc_qlut.sv
module sc_qlut #(
  parameter int ADDR_W = 9,
  parameter int MAG_W  = 12,
  parameter int AMP    = 2047
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  mag_sin,
  output logic [MAG_W-1:0]  mag_cos
);
  import sc_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = 2 * DEPTH;

  logic [2*MAG_W-1:0] rom [DEPTH];

  // each entry packs cosine (upper half) above sine (lower half)
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign rom[g] = {MAG_W'(qwave_val(DEPTH - g, HALF, AMP)),
                     MAG_W'(qwave_val(g, HALF, AMP))};
  end

  assign mag_cos = rom[addr][2*MAG_W-1:MAG_W];
  assign mag_sin = rom[addr][MAG_W-1:0];
endmodule

// File: rtl/sc_quad.sv
module sc_quad #(
  parameter int MAG_W = 12
) (
  input  logic [1:0]              quad,
  input  logic [MAG_W-1:0]        mag_sin,
  input  logic [MAG_W-1:0]        mag_cos,
  output logic signed [MAG_W-1:0] sin_o,
  output logic signed [MAG_W-1:0] cos_o
);
  logic signed [MAG_W-1:0] s_p, c_p;

  assign s_p = mag_sin;
  assign c_p = mag_cos;

  // fold the first-quadrant pair out to the full circle
  always_comb begin
    unique case (quad)
      2'd0: begin sin_o =  s_p; cos_o =  c_p; end
      2'd1: begin sin_o =  c_p; cos_o = -s_p; end
      2'd2: begin sin_o = -s_p; cos_o = -c_p; end
      default: begin sin_o = -c_p; cos_o =  s_p; end
    endcase
  end
endmodule

// File: rtl/sc_burst_loop.sv
module sc_burst_loop #(
  parameter int SEED_W = 32,
  parameter int VF_W   = 16,
  parameter int NB     = 32,
  parameter int SH_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     burst_gate,
  input  logic signed [VF_W-1:0]   vfilt,
  input  logic [SH_W-1:0]          err_shift,
  input  logic [SEED_W-1:0]        corr_limit,
  input  logic [SEED_W-1:0]        base_seed,
  output logic [SEED_W-1:0]        step,
  output logic signed [SEED_W-1:0] corr
);
  localparam int CNT_W = $clog2(NB + 1);
  localparam int EW    = VF_W + $clog2(NB) + 1;
  localparam int XW    = SEED_W + 1;

  logic                  gate_q;
  logic [CNT_W-1:0]      cnt_q;
  logic signed [EW-1:0]  err_q;
  logic signed [EW-1:0]  vf_ext;
  logic signed [EW-1:0]  shifted;
  logic signed [XW-1:0]  sh_ext, lim_p, lim_n, clamped;
  logic signed [SEED_W-1:0] corr_q;

  assign vf_ext  = {{(EW-VF_W){vfilt[VF_W-1]}}, vfilt};
  assign shifted = err_q >>> err_shift;
  assign sh_ext  = {{(XW-EW){shifted[EW-1]}}, shifted};
  assign lim_p   = {1'b0, corr_limit};
  assign lim_n   = -lim_p;

  always_comb begin
    if (sh_ext > lim_p)      clamped = lim_p;
    else if (sh_ext < lim_n) clamped = lim_n;
    else                     clamped = sh_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= '0;
      corr_q <= '0;
    end else begin
      gate_q <= burst_gate;
      if (burst_gate && !gate_q) begin
        err_q <= vf_ext;
        cnt_q <= CNT_W'(1);
      end else if (burst_gate && (cnt_q < CNT_W'(NB))) begin
        err_q <= err_q + vf_ext;
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (!burst_gate && gate_q) corr_q <= clamped[SEED_W-1:0];
    end
  end

  assign corr = corr_q;
  assign step = base_seed + corr_q;
endmodule

// File: rtl/sc_demod.sv
module sc_demod #(
  parameter int SAMP_W  = 10,
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 11,
  parameter int TRIG_W  = 12,
  parameter int VF_W    = 16,
  parameter int NB      = 32,
  parameter int SH_W    = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [SAMP_W-1:0]                    in_sample,
  input  logic                                 burst_gate,
  input  logic signed [VF_W-1:0]               vfilt,
  input  logic [ACC_W-1:0]                     base_seed,
  input  logic [SH_W-1:0]                      err_shift,
  input  logic [ACC_W-1:0]                     corr_limit,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic signed [SAMP_W+TRIG_W:0]        out_u,
  output logic signed [SAMP_W+TRIG_W:0]        out_v,
  output logic signed [TRIG_W-1:0]             out_sin,
  output logic signed [TRIG_W-1:0]             out_cos
);
  localparam int QA_W  = PHASE_W - 2;
  localparam int OUT_W = SAMP_W + TRIG_W + 1;
  localparam int AMP   = (1 << (TRIG_W - 1)) - 1;

  logic                     accept;
  logic [ACC_W-1:0]         step_w;
  logic signed [ACC_W-1:0]  corr_w;
  logic [PHASE_W-1:0]       phase_w;
  logic [TRIG_W-1:0]        m_sin, m_cos;
  logic signed [TRIG_W-1:0] sin_w, cos_w;
  logic signed [OUT_W-1:0]  x_e, s_e, c_e;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  sc_burst_loop #(.SEED_W(ACC_W), .VF_W(VF_W), .NB(NB), .SH_W(SH_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .burst_gate(burst_gate), .vfilt(vfilt),
    .err_shift(err_shift), .corr_limit(corr_limit), .base_seed(base_seed),
    .step(step_w), .corr(corr_w)
  );

  sc_nco #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .advance(accept), .step(step_w), .phase(phase_w)
  );

  sc_qlut #(.ADDR_W(QA_W), .MAG_W(TRIG_W), .AMP(AMP)) u_lut (
    .addr(phase_w[QA_W-1:0]), .mag_sin(m_sin), .mag_cos(m_cos)
  );

  sc_quad #(.MAG_W(TRIG_W)) u_quad (
    .quad(phase_w[PHASE_W-1 -: 2]), .mag_sin(m_sin), .mag_cos(m_cos),
    .sin_o(sin_w), .cos_o(cos_w)
  );

  assign x_e = {{(OUT_W-SAMP_W){1'b0}}, in_sample};
  assign s_e = {{(OUT_W-TRIG_W){sin_w[TRIG_W-1]}}, sin_w};
  assign c_e = {{(OUT_W-TRIG_W){cos_w[TRIG_W-1]}}, cos_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_u     <= '0;
      out_v     <= '0;
      out_sin   <= '0;
      out_cos   <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_u     <= x_e * s_e;
        out_v     <= x_e * c_e;
        out_sin   <= sin_w;
        out_cos   <= cos_w;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sc_demod_chk.sv
module sc_demod_chk #(
  parameter int OUT_W  = 23,
  parameter int TRIG_W = 12,
  parameter int ACC_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [OUT_W-1:0]  out_u,
  input logic signed [OUT_W-1:0]  out_v,
  input logic signed [TRIG_W-1:0] out_sin,
  input logic signed [TRIG_W-1:0] out_cos,
  input logic                     burst_gate,
  input logic [ACC_W-1:0]         corr_limit,
  input logic signed [ACC_W-1:0]  corr
);
  localparam int AMP = (1 << (TRIG_W - 1)) - 1;

  logic signed [ACC_W:0] corr_x, corr_mag;
  assign corr_x   = {corr[ACC_W-1], corr};
  assign corr_mag = corr_x[ACC_W] ? -corr_x : corr_x;

  // R6: an accepted sample yields a result on the next clock
  p_accept_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6: a stalled result stays frozen
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_u) && $stable(out_v)
                                   && $stable(out_sin) && $stable(out_cos)));

  // R6: no sample is taken while a result is stalled
  p_stall_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4: trig values stay inside the amplitude
  p_trig_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sin >= -AMP && out_sin <= AMP && out_cos >= -AMP && out_cos <= AMP));

  // R5: a zero trig value gives a zero product
  p_zero_prod_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sin != 0 || out_u == 0) && (out_cos != 0 || out_v == 0)));

  // R9: a fresh correction never exceeds the limit
  p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_gate) |=> (corr_mag <= $signed({1'b0, $past(corr_limit)})));

  // R10: the correction only moves at a burst end
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(burst_gate) |=> $stable(corr));
endmodule

bind sc_demod sc_demod_chk #(.OUT_W(OUT_W), .TRIG_W(TRIG_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_u(out_u), .out_v(out_v),
  .out_sin(out_sin), .out_cos(out_cos), .burst_gate(burst_gate),
  .corr_limit(corr_limit), .corr(corr_w)
);

// File: tb/sc_demod_tb.sv
module sc_demod_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [9:0] in_sample = '0;
  logic burst_gate = 1'b0;
  logic signed [15:0] vfilt = '0;
  logic [31:0] base_seed = 32'h5541_7954;
  logic [4:0] err_shift = '0;
  logic [31:0] corr_limit = 32'hFFFF_FFFF;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [22:0] out_u, out_v;
  logic signed [11:0] out_sin, out_cos;

  always #10 clk = ~clk;

  sc_demod u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .burst_gate(burst_gate), .vfilt(vfilt),
    .base_seed(base_seed), .err_shift(err_shift), .corr_limit(corr_limit),
    .out_valid(out_valid), .out_ready(out_ready), .out_u(out_u), .out_v(out_v),
    .out_sin(out_sin), .out_cos(out_cos)
  );

  typedef struct { int samp; int ph; int exact; } item_t;
  item_t sb[$];

  int total = 0;
  int bad = 0;
  logic [31:0] bacc = '0;
  logic [31:0] bstep = 32'h5541_7954;
  logic [15:0] lfsr = 16'hACE1;
  bit held = 0;
  logic signed [22:0] h_u, h_v;
  logic signed [11:0] h_s, h_c;
  int nsamp = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor and scoreboard step, called 1 time unit after each falling edge
  task automatic mon_step(input int exact_flag);
    item_t it;
    real es, ec;
    if (held)
      check(out_u == h_u && out_v == h_v && out_sin == h_s && out_cos == h_c,
            "R6", "stalled output changed", longint'(out_u), longint'(h_u));
    held = out_valid && !out_ready;
    h_u = out_u; h_v = out_v; h_s = out_sin; h_c = out_cos;
    if (out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6", "result with no pending sample", 1, 0);
      end else begin
        it = sb.pop_front();
        es = 2047.0 * $sin(2.0 * 3.14159265358979 * it.ph / 2048.0);
        ec = 2047.0 * $cos(2.0 * 3.14159265358979 * it.ph / 2048.0);
        // R2 + R4: trig follows the bench phase model
        check((real'(out_sin) - es) <= 6.0 && (es - real'(out_sin)) <= 6.0,
              "R4", $sformatf("sine at phase %0d", it.ph), longint'(out_sin), longint'($rtoi(es)));
        check((real'(out_cos) - ec) <= 6.0 && (ec - real'(out_cos)) <= 6.0,
              "R4", $sformatf("cosine at phase %0d", it.ph), longint'(out_cos), longint'($rtoi(ec)));
        check(longint'(out_u) == longint'(it.samp) * longint'(out_sin), "R5", "raw U",
              longint'(out_u), longint'(it.samp) * longint'(out_sin));
        check(longint'(out_v) == longint'(it.samp) * longint'(out_cos), "R5", "raw V",
              longint'(out_v), longint'(it.samp) * longint'(out_cos));
        if (it.exact != 0) begin
          // R3: exact quadrant-start values
          case (it.ph)
            0:    check(out_sin == 0 && out_cos == 2047, "R3", "quadrant 0 start", longint'(out_sin), 0);
            512:  check(out_sin == 2047 && out_cos == 0, "R3", "quadrant 1 start", longint'(out_sin), 2047);
            1024: check(out_sin == 0 && out_cos == -2047, "R3", "quadrant 2 start", longint'(out_cos), -2047);
            1536: check(out_sin == -2047 && out_cos == 0, "R3", "quadrant 3 start", longint'(out_sin), -2047);
            default: check(1'b0, "R3", "unexpected phase", longint'(it.ph), 0);
          endcase
        end
      end
    end
    if (in_valid && in_ready) begin
      it.samp = int'(in_sample);
      it.ph = int'(bacc[31:21]);
      it.exact = exact_flag;
      sb.push_back(it);
      bacc = bacc + bstep;
      nsamp++;
    end
  endtask

  // stream n samples; stall_mode drops out_ready on some clocks
  task automatic stream(input int n, input bit stall_mode, input int exact_flag);
    int got;
    got = nsamp;
    while (nsamp - got < n) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
      in_valid = 1'b1;
      in_sample = (lfsr[3:0] == 4'hF) ? 10'd1023 : lfsr[9:0];
      vfilt = $signed(lfsr);
      #1 mon_step(exact_flag);
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1 mon_step(0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1 mon_step(0);
    end
    check(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
  endtask

  // one burst: 32 clocks of 'first', 8 more of 'late', then gate low
  task automatic burst(input int first, input int late, input int sh, input logic [31:0] lim);
    longint err, c;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    err_shift = 5'(sh); corr_limit = lim;
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      burst_gate = 1'b1;
      vfilt = 16'(k < 32 ? first : late);
      #1 mon_step(0);
    end
    @(negedge clk);
    burst_gate = 1'b0;
    vfilt = 16'sh1234;
    #1 mon_step(0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      vfilt = 16'(-7777 + 999 * k);
      #1 mon_step(0);
    end
    err = 32 * longint'(first);
    c = err >>> sh;
    if (c > longint'(lim)) c = longint'(lim);
    if (c < -longint'(lim)) c = -longint'(lim);
    bstep = base_seed + 32'(c);
  endtask

  initial begin
    #3_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);

    // R1 + R2: first result uses phase 0, typical step, free flow
    bacc = '0; bstep = 32'h5541_7954;
    stream(60, 1'b0, 0);

    // R3: quarter-turn steps hit quadrant starts exactly
    base_seed = 32'h4000_0000; bstep = 32'h4000_0000;
    bacc = bacc; // accumulator continues from current value
    stream(1, 1'b0, 0);
    // align to a quadrant start: accumulator is a multiple of 2^30 only if reset;
    // restart from reset to keep the quadrant walk exact
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; bacc = '0;
    stream(9, 1'b0, 1);

    // R2 + R4 + R5 + R6: one phase word per sample, heavy stalls
    base_seed = 32'h0020_0000; bstep = 32'h0020_0000;
    stream(700, 1'b1, 0);

    // loop tests run with a zero base step
    base_seed = 32'h0; bstep = 32'h0;
    // R7 + R8: only the first 32 feedback values count
    burst(16384, 32767, 0, 32'hFFFF_FFFF);
    check(bstep == 32'h0008_0000, "R7", "bench step model", longint'(bstep), 32'h80000);
    stream(60, 1'b1, 0);
    // R8: shift scales the error
    burst(16384, -30000, 2, 32'hFFFF_FFFF);
    stream(60, 1'b0, 0);
    // R9: positive clamp
    burst(16384, 0, 0, 32'd262144);
    stream(60, 1'b1, 0);
    // R8: negative error steps backwards
    burst(-16384, 5000, 0, 32'hFFFF_FFFF);
    stream(60, 1'b0, 0);
    // R9: negative clamp with a non-power-of-two limit
    burst(-16384, 0, 0, 32'd100000);
    // R10: feedback keeps toggling with the gate low while samples stream
    stream(120, 1'b1, 0);

    report();
  end
endmodule